// File: doc/BRIEF.md
# Windowed Watchdog Service Controller

This block watches over a running program by counting instruction-cycle ticks and expecting software to service it at regular intervals. Software services it by writing one register that carries a 5-bit key and a 2-bit window select. A service counts only if the key is right and it lands inside the window. The window opens 256 ticks after the last restart and closes at the selected upper bound. A service that comes too early, carries a wrong key, or never comes before the bound raises a one-cycle error pulse, and the window restarts.

The block is also aware of low-power modes. While the halt or idle input is high, counting stops and writes are ignored. Leaving idle acts as a service done by hardware: the window restarts, and the 256-tick lower bound applies again. Leaving halt depends on a clock-delay option bit:
- With the bit clear, the count picks up where it stopped.
- With the bit set, the window restarts, as it does on leaving idle.

The controller is a four-state machine:
- `WD_FIRST` is the initial window after reset. It has no lower bound and uses the 64K window.
- `WD_ARMED` is the normal window.
- `WD_HALT` and `WD_IDLE` are the two frozen states.

Its transitions are:
- first/armed to halt when halt is high.
- first/armed to idle when idle is high and halt is low.
- first/armed to armed on any write, valid or failed, and on a timeout.
- halt back to first or armed when both low-power inputs are low and the option bit is clear. It returns to the state it left.
- halt to armed, with a restart, when both low-power inputs are low and the option bit is set.
- idle to armed, with a restart, when both low-power inputs are low.

Top module: `wdog_window_ctrl`

## Requirements
- R1: After reset `err_o` is 0, the window select reads back as 2'b11 (the 65,536-tick window), and the key field reads back as zero.
- R2: The elapsed count advances only on a clock edge with `tick_en` high while neither `halt_i` nor `idle_i` is high. Dropping `tick_en` delays a timeout by exactly the number of edges it was low.
- R3: In the first window after reset, a write whose key field `wr_data[6:2]` is 5'b01100 is accepted at any count, including counts below 256.
- R4: Outside the first window, a correct-key write at a count below 256 raises `err_o` in the next cycle. It also restarts the count and leaves the window select unchanged. A write at count 255 is early; one at count 256 is accepted.
- R5: A write whose key field is not 5'b01100 raises `err_o` in the next cycle, restarts the count, and leaves the select unchanged. This applies in the first window as well.
- R6: An accepted write clears the count and latches `wr_data[1:0]` as the window select. The codes 0, 1, 2 and 3 select bounds of 2,048, 8,192, 16,384 and 65,536 ticks. The select appears in `rd_data[1:0]`, and `rd_data[6:2]` always reads zero.
- R7: When the count reaches the selected bound with no accepted write, `err_o` pulses for one cycle and the count restarts. A write at count bound-1 is still accepted.
- R8: During halt the count is frozen. With `clk_dly_i` at 0, leaving halt resumes from the frozen count; the exit edge itself counts no tick.
- R9: With `clk_dly_i` at 1, leaving halt restarts the count at zero in the normal window, so the 256-tick lower bound applies.
- R10: During idle the count is frozen and no timeout occurs. Leaving idle restarts the count at zero, with the lower bound applied.
- R11: Writes made while `halt_i` or `idle_i` is high, or while the block is halted or idled, raise no error and change no state.
- R12: `err_o` is high only in the cycle after an edge with a counted tick or a write while the block is running. No pulse occurs without one of the causes above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Instruction-cycle enable; one tick per edge while high |
| halt_i | input | 1 | Halt mode active |
| idle_i | input | 1 | Idle mode active |
| clk_dly_i | input | 1 | Option bit: 1 restarts the window when halt ends |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 7 | Write data: key in [6:2], window select in [1:0] |
| rd_data | output | 7 | Readback: zeros in [6:2], latched select in [1:0] |
| err_o | output | 1 | One-cycle watchdog error pulse |

## Verification
An error from a write, early or with a bad key, is due in the cycle right after the edge that samples the write. A timeout error is due exactly bound edges after the edge that restarted the count, plus one edge for each edge on which counting was gated off. Leaving halt or idle adds one uncounted edge at the exit.

The bench keeps a free-running edge counter. It stamps every expected result with the edge number at which it must appear, and a monitor compares at the falling edge after that number. Any `err_o` pulse with no stamped expectation is itself a failure.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Controller states
    typedef enum logic [1:0] {
        WD_FIRST = 2'd0,   // initial window after reset, no lower bound
        WD_ARMED = 2'd1,   // normal window, lower bound applies
        WD_HALT  = 2'd2,   // counting frozen, resume depends on option bit
        WD_IDLE  = 2'd3    // counting frozen, exit performs a service
    } wd_state_e;

endpackage

// File: rtl/wdog_svc_decode.sv
module wdog_svc_decode #(
    parameter int KEY_W = 5,
    parameter int SEL_W = 2,
    parameter logic [KEY_W-1:0] KEY_VAL = 5'b01100
) (
    input  logic [KEY_W+SEL_W-1:0] wr_data,
    output logic                   key_ok,
    output logic [SEL_W-1:0]       sel_req
);

    localparam int DW = KEY_W + SEL_W;

    assign key_ok  = (wr_data[DW-1 -: KEY_W] == KEY_VAL);
    assign sel_req = wr_data[SEL_W-1:0];

endmodule

// File: rtl/wdog_win_limit.sv
module wdog_win_limit #(
    parameter int SEL_W = 2,
    parameter int LG_W  = 5,
    parameter int CNT_W = 16,
    parameter logic [(2**SEL_W)*LG_W-1:0] WIN_LOG2 = {5'd16, 5'd14, 5'd13, 5'd11}
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] lim
);

    localparam int NUM_WIN = 2 ** SEL_W;

    // Last legal count (bound - 1) for each window code
    logic [CNT_W-1:0] tbl [NUM_WIN];

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            localparam int LG = int'(WIN_LOG2[g*LG_W +: LG_W]);
            assign tbl[g] = {CNT_W{1'b1}} >> (CNT_W - LG);
        end
    endgenerate

    assign lim = tbl[sel];

endmodule

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_SVC = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             idle_i,
    input  logic             clk_dly_i,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic             key_ok,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lim,
    output wd_state_e        state,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             sel_ld,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_SVC);

    wd_state_e nxt;
    logic      ret_first;   // halt was entered from the first window
    logic      err_d;
    logic      asleep_req;
    logic      early;

    assign asleep_req = halt_i | idle_i;
    assign early      = (cnt < MIN_CNT);

    // Next state and per-cycle controls
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        sel_ld  = 1'b0;
        err_d   = 1'b0;
        unique case (state)
            WD_FIRST, WD_ARMED: begin
                if (halt_i) begin
                    nxt = WD_HALT;
                end else if (idle_i) begin
                    nxt = WD_IDLE;
                end else if (wr_en) begin
                    nxt     = WD_ARMED;
                    cnt_clr = 1'b1;
                    if (!key_ok) begin
                        err_d = 1'b1;
                    end else if (state == WD_ARMED && early) begin
                        err_d = 1'b1;
                    end else begin
                        sel_ld = 1'b1;
                    end
                end else if (tick_en) begin
                    if (cnt >= lim) begin
                        nxt     = WD_ARMED;
                        err_d   = 1'b1;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            WD_HALT: begin
                if (!asleep_req) begin
                    if (clk_dly_i) begin
                        nxt     = WD_ARMED;
                        cnt_clr = 1'b1;
                    end else begin
                        nxt = ret_first ? WD_FIRST : WD_ARMED;
                    end
                end
            end
            WD_IDLE: begin
                if (!asleep_req) begin
                    nxt     = WD_ARMED;
                    cnt_clr = 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= WD_FIRST;
            ret_first <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == WD_HALT && state != WD_HALT) begin
                ret_first <= (state == WD_FIRST);
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else begin
            err_o <= err_d;
        end
    end

endmodule

// File: rtl/wdog_window_ctrl.sv
module wdog_window_ctrl
    import wdog_pkg::*;
#(
    parameter int KEY_W   = 5,
    parameter int SEL_W   = 2,
    parameter int LG_W    = 5,
    parameter logic [KEY_W-1:0] KEY_VAL = 5'b01100,
    parameter int MIN_SVC = 256,
    parameter logic [(2**SEL_W)*LG_W-1:0] WIN_LOG2 = {5'd16, 5'd14, 5'd13, 5'd11}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   halt_i,
    input  logic                   idle_i,
    input  logic                   clk_dly_i,
    input  logic                   wr_en,
    input  logic [KEY_W+SEL_W-1:0] wr_data,
    output logic [KEY_W+SEL_W-1:0] rd_data,
    output logic                   err_o
);

    localparam int NUM_WIN = 2 ** SEL_W;
    localparam int CNT_W   = int'(WIN_LOG2[NUM_WIN*LG_W-1 -: LG_W]);

    wd_state_e        st;
    logic             key_ok;
    logic [SEL_W-1:0] sel_req;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             sel_ld;

    wdog_svc_decode #(
        .KEY_W   (KEY_W),
        .SEL_W   (SEL_W),
        .KEY_VAL (KEY_VAL)
    ) u_dec (
        .wr_data (wr_data),
        .key_ok  (key_ok),
        .sel_req (sel_req)
    );

    wdog_win_limit #(
        .SEL_W    (SEL_W),
        .LG_W     (LG_W),
        .CNT_W    (CNT_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_lim (
        .sel (sel_q),
        .lim (lim)
    );

    wdog_tick_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt_q)
    );

    wdog_fsm #(
        .CNT_W   (CNT_W),
        .MIN_SVC (MIN_SVC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (halt_i),
        .idle_i    (idle_i),
        .clk_dly_i (clk_dly_i),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .key_ok    (key_ok),
        .cnt       (cnt_q),
        .lim       (lim),
        .state     (st),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .sel_ld    (sel_ld),
        .err_o     (err_o)
    );

    // Window select, largest window out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '1;
        end else if (sel_ld) begin
            sel_q <= sel_req;
        end
    end

    assign rd_data = {{KEY_W{1'b0}}, sel_q};

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
    import wdog_pkg::*;
#(
    parameter int KEY_W = 5,
    parameter int SEL_W = 2,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   halt_i,
    input  logic                   idle_i,
    input  logic                   wr_en,
    input  logic [KEY_W+SEL_W-1:0] rd_data,
    input  logic                   err_o,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [CNT_W-1:0]       lim,
    input  wd_state_e              st
);

    localparam int DW = KEY_W + SEL_W;

    logic running;
    assign running = (st == WD_FIRST) || (st == WD_ARMED);

    AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n) !$past(rst_n) |-> (rd_data == DW'({SEL_W{1'b1}}) && !err_o)) else $error("reset default");  // R1
    AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (halt_i || idle_i) |=> $stable(cnt)) else $error("count moved while asleep");  // R2
    AST_TIMEOUT_FIRES: assert property (@(posedge clk) disable iff (!rst_n) (running && !halt_i && !idle_i && !wr_en && tick_en && cnt == lim) |=> (err_o && cnt == '0)) else $error("timeout missed");  // R7
    AST_COUNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= lim) else $error("count beyond bound");  // R7
    AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !$past(wr_en) |-> $stable(rd_data)) else $error("select changed without write");  // R6
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) err_o |-> $past(!halt_i && !idle_i && (wr_en || tick_en))) else $error("error without cause");  // R12

endmodule

bind wdog_window_ctrl wdog_window_chk #(
    .KEY_W (KEY_W),
    .SEL_W (SEL_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .halt_i  (halt_i),
    .idle_i  (idle_i),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .err_o   (err_o),
    .cnt     (cnt_q),
    .lim     (lim),
    .st      (st)
);

// File: tb/sim_wdog_window_ctrl.sv
module sim_wdog_window_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] KEY    = 5'b01100;
    localparam logic [4:0] BADKEY = 5'b01101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       halt_i = 1'b0;
    logic       idle_i = 1'b0;
    logic       clk_dly_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic [6:0] rd_data;
    logic       err_o;

    typedef struct {
        int unsigned cyc;
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    exp_t        it;
    logic        hit;
    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    wdog_window_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .halt_i    (halt_i),
        .idle_i    (idle_i),
        .clk_dly_i (clk_dly_i),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .err_o     (err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Driver side
    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int unsigned at, input logic e, input string tag);
        exp_t x;
        x.cyc = at; x.err = e; x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic svc(input logic [4:0] k, input logic [1:0] s, input logic e, input string tag);
        wr_en   = 1'b1;
        wr_data = {k, s};
        push(cyc + 1, e, tag);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic check_val(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor side
    always @(negedge clk) begin
        hit = 1'b0;
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                it = sb.pop_front();
                checks++;
                if (it.cyc != cyc) begin
                    errors++;
                    $display("FAIL %s: result missed at cycle %0d, actual none expected %0d", it.tag, it.cyc, it.err);
                end else begin
                    hit = 1'b1;
                    if (err_o !== it.err) begin
                        errors++;
                        $display("FAIL %s: err_o actual %0b expected %0b at cycle %0d", it.tag, err_o, it.err, cyc);
                    end
                end
            end
            if (err_o && !hit) begin
                errors++;
                $display("FAIL R12: err_o actual 1 expected 0 at cycle %0d", cyc);
            end
        end
    end

    initial begin
        run(5);
        rst_n = 1'b1;
        // R1 reset state
        check_val(int'(err_o), 0, "R1 err after reset");
        check_val(int'(rd_data), 3, "R1 readback after reset");

        // R3 early service in first window is legal
        run(10);
        svc(KEY, 2'd0, 1'b0, "R3 first service at count 10");
        check_val(int'(rd_data), 0, "R6 select latched, key reads zero");

        // R4 early service in armed window
        run(100);
        svc(KEY, 2'd2, 1'b1, "R4 early service");
        check_val(int'(rd_data), 0, "R4 select unchanged after early service");
        run(255);
        svc(KEY, 2'd1, 1'b1, "R4 service at count 255");
        run(256);
        svc(KEY, 2'd1, 1'b0, "R4 service at count 256");
        check_val(int'(rd_data), 1, "R6 select 1 latched");

        // R5 wrong key
        run(300);
        svc(BADKEY, 2'd0, 1'b1, "R5 wrong key");
        check_val(int'(rd_data), 1, "R5 select unchanged");

        // R6/R7 2K window, last legal count and timeout
        run(300);
        svc(KEY, 2'd0, 1'b0, "R6 select 2K window");
        run(2047);
        svc(KEY, 2'd0, 1'b0, "R7 service at bound-1");
        push(cyc + 2048, 1'b1, "R7 timeout after 2048 ticks");
        run(2048);
        run(300);
        svc(KEY, 2'd0, 1'b0, "R7 service after timeout restart");

        // R2 tick gating
        run(1000);
        tick_en = 1'b0;
        run(3000);
        tick_en = 1'b1;
        push(cyc + 1048, 1'b1, "R2 timeout delayed by gated ticks");
        run(1048);
        run(300);
        svc(KEY, 2'd0, 1'b0, "R2 service after gated timeout");

        // R8 halt with resume, R11 write during halt
        run(1000);
        halt_i = 1'b1;
        run(2000);
        svc(BADKEY, 2'd2, 1'b0, "R11 write ignored in halt");
        check_val(int'(rd_data), 0, "R11 select unchanged in halt");
        run(2999);
        halt_i = 1'b0;
        push(cyc + 1049, 1'b1, "R8 timeout resumes after halt");
        run(1049);
        run(300);
        svc(KEY, 2'd0, 1'b0, "R8 service after resume");

        // R9 halt with restart option
        run(1000);
        clk_dly_i = 1'b1;
        halt_i    = 1'b1;
        run(50);
        halt_i = 1'b0;
        run(1);
        run(255);
        svc(KEY, 2'd0, 1'b1, "R9 lower bound after halt restart");
        run(256);
        svc(KEY, 2'd0, 1'b0, "R9 service at 256 after restart");
        clk_dly_i = 1'b0;

        // R10 idle freeze, hardware service on exit
        run(500);
        idle_i = 1'b1;
        run(1500);
        svc(BADKEY, 2'd3, 1'b0, "R11 write ignored in idle");
        run(1499);
        idle_i = 1'b0;
        run(1);
        run(100);
        svc(KEY, 2'd0, 1'b1, "R10 lower bound after idle exit");
        run(300);
        svc(KEY, 2'd0, 1'b0, "R10 service after early error");
        run(1500);
        idle_i = 1'b1;
        run(10);
        idle_i = 1'b0;
        run(1);
        push(cyc + 2048, 1'b1, "R10 window restarted at idle exit");
        run(2048);
        run(5);

        // R5 in first window, R7 64K window after reset
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        check_val(int'(rd_data), 3, "R1 readback after second reset");
        run(5);
        svc(BADKEY, 2'd0, 1'b1, "R5 wrong key in first window");
        check_val(int'(rd_data), 3, "R5 select unchanged in first window");
        push(cyc + 65536, 1'b1, "R7 timeout of 64K window");
        run(65536);
        run(5);

        check_val(sb.size(), 0, "R12 scoreboard drained");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule